// File: doc/BRIEF.md
# Vertical-First Element Step Controller

This block keeps the source and destination element indices used by a vector unit running in vertical-first mode. In that mode ordinary vector instructions work on one element and leave both indices alone; only an explicit step command moves them. On an accepted step, each index jumps forward to the next element whose predicate bit is set and that lies below the current vector length (VL). If either index has no such element left, the step counts as the end of the vector: both indices return to zero and the end flag is raised.

Every accepted step also produces a registered result. A 3-bit selector either picks one of four externally supplied loop-end sets (inner, middle, outer) for the condition flags, or picks the new source or destination index as the return value. The condition flags are produced only when the record bit is set. The return value is produced only when the destination register is nonzero. Results hold their value until the next accepted step.

Top module: `vfs_step_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, src_step_o, dst_step_o, end_o, res_valid_o, cr_o and ret_o are all zero.
- R2: A step command is accepted only when vf_i=1, vs_i=0 and ms_i=0. With any other mode combination, step_i leaves both indices and all result outputs unchanged, and res_valid_o stays low.
- R3: In a cycle with step_i low, both indices and all result outputs are unchanged on the next cycle.
- R4: One cycle after an accepted step, src_step_o is the smallest index greater than its previous value whose src_mask_i bit is set and that is below vl_i. dst_step_o is found the same way from dst_mask_i, independently.
- R5: If either search in R4 finds no element, then one cycle after the step both indices are 0 and end_o is 1. Otherwise end_o is 0 after the step.
- R6: res_valid_o is high for exactly the one cycle that follows each accepted step.
- R7: With rc_i=1 and sel_i in 1..4, loop-end set k=sel_i-1 is the field remap_end_i[3k+2:3k], with bit 3k = inner, 3k+1 = middle and 3k+2 = outer. After the step, cr_o[0]=inner, cr_o[1]=middle and cr_o[2]=outer.
- R8: With rc_i=1, cr_o[3] equals the new end_o, and cr_o[2:0] is 0 for sel_i values outside 1..4. With rc_i=0, cr_o is 0 after the step.
- R9: After an accepted step with rt_nz_i=1, ret_o is the new src_step_o when sel_i=5 and the new dst_step_o when sel_i=6. In every other case ret_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Step command |
| vf_i | input | 1 | Vertical-first mode bit |
| vs_i | input | 1 | Length-set mode bit (must be 0 to step) |
| ms_i | input | 1 | Max-length-set mode bit (must be 0 to step) |
| rc_i | input | 1 | Record bit; enables condition flags |
| rt_nz_i | input | 1 | Destination register is nonzero; enables return value |
| sel_i | input | 3 | Selector immediate |
| src_mask_i | input | MAX_VL | Source predicate mask |
| dst_mask_i | input | MAX_VL | Destination predicate mask |
| vl_i | input | VL_W | Current vector length, 0..MAX_VL |
| remap_end_i | input | 12 | Four loop-end sets of three bits each |
| src_step_o | output | IDX_W | Source element index |
| dst_step_o | output | IDX_W | Destination element index |
| end_o | output | 1 | Last step reached the end of the vector |
| res_valid_o | output | 1 | Result outputs updated in the previous cycle |
| cr_o | output | 4 | Condition flags {vl_end, outer, middle, inner} |
| ret_o | output | IDX_W | Selected return index |

## Verification
The assertions assume that the mode bits, selector and masks are valid in the same cycle as step_i, and that vl_i never exceeds MAX_VL. Under those assumptions an index search can only move forward or end. The stimulus always drives every input together at the falling edge and keeps vl_i within 0..64. It walks the indices through gapped masks, through empty tails, up to the top element 63, and through vl_i of zero, so that both the advance path and the end path are reached with each selector class.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  localparam int NUM_SETS  = 4;
  localparam int SET_LOOPS = 3;
  localparam int REMAP_W   = NUM_SETS * SET_LOOPS;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_LS0  = 3'd1,
    SEL_LS1  = 3'd2,
    SEL_LS2  = 3'd3,
    SEL_LS3  = 3'd4,
    SEL_SRC  = 3'd5,
    SEL_DST  = 3'd6,
    SEL_RSV  = 3'd7
  } sel_e;
endpackage

// File: rtl/vfs_next_find.sv
module vfs_next_find #(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = $clog2(MAX_VL),
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic [IDX_W-1:0]  cur_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic [VL_W-1:0]   vl_i,
  output logic [IDX_W-1:0]  nxt_o,
  output logic              found_o
);
  // descending scan leaves the lowest qualifying index
  always_comb begin
    nxt_o   = '0;
    found_o = 1'b0;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (mask_i[i] && (i > int'(cur_i)) && (i < int'(vl_i))) begin
        nxt_o   = IDX_W'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vfs_flag_sel.sv
module vfs_flag_sel
  import vfs_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [2:0]         sel_i,
  input  logic               rc_i,
  input  logic               rt_nz_i,
  input  logic               end_i,
  input  logic [REMAP_W-1:0] remap_end_i,
  input  logic [IDX_W-1:0]   src_i,
  input  logic [IDX_W-1:0]   dst_i,
  output logic [3:0]         cr_o,
  output logic [IDX_W-1:0]   ret_o
);
  logic [SET_LOOPS-1:0] loop_bits;

  always_comb begin
    loop_bits = '0;
    ret_o     = '0;
    unique case (sel_e'(sel_i))
      SEL_LS0, SEL_LS1, SEL_LS2, SEL_LS3:
        loop_bits = remap_end_i[(int'(sel_i) - 1) * SET_LOOPS +: SET_LOOPS];
      SEL_SRC: if (rt_nz_i) ret_o = src_i;
      SEL_DST: if (rt_nz_i) ret_o = dst_i;
      default: ;
    endcase
    cr_o = rc_i ? {end_i, loop_bits} : 4'b0;
  end
endmodule

// File: rtl/vfs_step_ctrl.sv
module vfs_step_ctrl
  import vfs_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = $clog2(MAX_VL),
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               vf_i,
  input  logic               vs_i,
  input  logic               ms_i,
  input  logic               rc_i,
  input  logic               rt_nz_i,
  input  logic [2:0]         sel_i,
  input  logic [MAX_VL-1:0]  src_mask_i,
  input  logic [MAX_VL-1:0]  dst_mask_i,
  input  logic [VL_W-1:0]    vl_i,
  input  logic [REMAP_W-1:0] remap_end_i,
  output logic [IDX_W-1:0]   src_step_o,
  output logic [IDX_W-1:0]   dst_step_o,
  output logic               end_o,
  output logic               res_valid_o,
  output logic [3:0]         cr_o,
  output logic [IDX_W-1:0]   ret_o
);
  localparam int NUM_PTR = 2;  // 0: source, 1: destination

  logic [IDX_W-1:0]  cur_q  [NUM_PTR];
  logic [MAX_VL-1:0] mask   [NUM_PTR];
  logic [IDX_W-1:0]  nxt    [NUM_PTR];
  logic [IDX_W-1:0]  nxt_ok [NUM_PTR];
  logic [NUM_PTR-1:0] found;

  logic       fire, hit_end;
  logic [3:0] cr_d;
  logic [IDX_W-1:0] ret_d;

  assign fire    = step_i & vf_i & ~vs_i & ~ms_i;
  assign mask[0] = src_mask_i;
  assign mask[1] = dst_mask_i;
  assign hit_end = ~&found;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    vfs_next_find #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .VL_W(VL_W)) u_find (
      .cur_i  (cur_q[g]),
      .mask_i (mask[g]),
      .vl_i   (vl_i),
      .nxt_o  (nxt[g]),
      .found_o(found[g])
    );
    assign nxt_ok[g] = hit_end ? '0 : nxt[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cur_q[g] <= '0;
      else if (fire) cur_q[g] <= nxt_ok[g];
    end
  end

  vfs_flag_sel #(.IDX_W(IDX_W)) u_flags (
    .sel_i      (sel_i),
    .rc_i       (rc_i),
    .rt_nz_i    (rt_nz_i),
    .end_i      (hit_end),
    .remap_end_i(remap_end_i),
    .src_i      (nxt_ok[0]),
    .dst_i      (nxt_ok[1]),
    .cr_o       (cr_d),
    .ret_o      (ret_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_o       <= 1'b0;
      res_valid_o <= 1'b0;
      cr_o        <= '0;
      ret_o       <= '0;
    end else begin
      res_valid_o <= fire;
      if (fire) begin
        end_o <= hit_end;
        cr_o  <= cr_d;
        ret_o <= ret_d;
      end
    end
  end

  assign src_step_o = cur_q[0];
  assign dst_step_o = cur_q[1];
endmodule

// File: rtl/vfs_step_chk.sv
module vfs_step_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_i,
  input logic             vf_i,
  input logic             vs_i,
  input logic             ms_i,
  input logic             rc_i,
  input logic             rt_nz_i,
  input logic [IDX_W-1:0] src_step_o,
  input logic [IDX_W-1:0] dst_step_o,
  input logic             end_o,
  input logic             res_valid_o,
  input logic [3:0]       cr_o,
  input logic [IDX_W-1:0] ret_o
);
  logic mode_ok;
  assign mode_ok = vf_i & ~vs_i & ~ms_i;

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(src_step_o) && $stable(dst_step_o) && $stable(ret_o));

  // R2
  mode_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !mode_ok) |=> $stable(src_step_o) && $stable(dst_step_o) && !res_valid_o);

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_ok) |=> res_valid_o);

  // R5
  end_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && end_o) |-> (src_step_o == '0) && (dst_step_o == '0));

  // R4
  forward_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_ok) |=> end_o ||
      ((src_step_o > $past(src_step_o)) && (dst_step_o > $past(dst_step_o))));

  // R8
  rc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_ok && !rc_i) |=> cr_o == 4'b0);

  // R9
  ret_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_ok && !rt_nz_i) |=> ret_o == '0);
endmodule

bind vfs_step_ctrl vfs_step_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .step_i     (step_i),
  .vf_i       (vf_i),
  .vs_i       (vs_i),
  .ms_i       (ms_i),
  .rc_i       (rc_i),
  .rt_nz_i    (rt_nz_i),
  .src_step_o (src_step_o),
  .dst_step_o (dst_step_o),
  .end_o      (end_o),
  .res_valid_o(res_valid_o),
  .cr_o       (cr_o),
  .ret_o      (ret_o)
);

// File: tb/sim_vfs_step_ctrl.sv
module sim_vfs_step_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_VL = 64;
  localparam int IDX_W  = 6;
  localparam int VL_W   = 7;

  typedef struct packed {
    logic        vf, vs, ms, step, rc, rtnz;
    logic [2:0]  sel;
    logic [63:0] sm, dm;
    logic [6:0]  vl;
    logic [11:0] rend;
    logic [5:0]  esrc, edst;
    logic        eend, evalid;
    logic [3:0]  ecr;
    logic [5:0]  eret;
  } vec_t;

  localparam logic [63:0] S1 = 64'h0000_0000_0000_00F4;  // bits 2,4,5,6,7
  localparam logic [63:0] D1 = 64'h0000_0000_0000_002A;  // bits 1,3,5
  localparam logic [63:0] HI = 64'h8000_0000_0000_0001;
  localparam logic [63:0] H2 = 64'h4000_0000_0000_0000;
  localparam logic [63:0] ON = '1;
  localparam int NV = 14;

  localparam vec_t TBL [NV] = '{
    '{1,0,0,1,1,1,3'd5,S1,D1,7'd8,12'h000,6'd2,6'd1,1'b0,1'b1,4'h0,6'd2},
    '{1,0,0,1,1,1,3'd6,S1,D1,7'd8,12'h000,6'd4,6'd3,1'b0,1'b1,4'h0,6'd3},
    '{1,0,0,0,1,1,3'd6,S1,D1,7'd8,12'h000,6'd4,6'd3,1'b0,1'b0,4'h0,6'd3},
    '{1,1,0,1,1,1,3'd6,S1,D1,7'd8,12'h000,6'd4,6'd3,1'b0,1'b0,4'h0,6'd3},
    '{1,0,0,1,1,1,3'd1,S1,D1,7'd8,12'h005,6'd5,6'd5,1'b0,1'b1,4'h5,6'd0},
    '{1,0,0,1,1,1,3'd3,S1,D1,7'd8,12'h180,6'd0,6'd0,1'b1,1'b1,4'hE,6'd0},
    '{1,0,0,1,0,0,3'd5,S1,D1,7'd8,12'h000,6'd2,6'd1,1'b0,1'b1,4'h0,6'd0},
    '{1,0,0,1,1,1,3'd5,S1,D1,7'd3,12'h000,6'd0,6'd0,1'b1,1'b1,4'h8,6'd0},
    '{1,0,1,1,1,1,3'd5,S1,D1,7'd3,12'h000,6'd0,6'd0,1'b1,1'b0,4'h8,6'd0},
    '{0,0,0,1,1,1,3'd5,S1,D1,7'd3,12'h000,6'd0,6'd0,1'b1,1'b0,4'h8,6'd0},
    '{1,0,0,1,1,1,3'd4,HI,H2,7'd64,12'h600,6'd63,6'd62,1'b0,1'b1,4'h3,6'd0},
    '{1,0,0,1,1,1,3'd4,HI,H2,7'd64,12'h600,6'd0,6'd0,1'b1,1'b1,4'hB,6'd0},
    '{1,0,0,1,0,0,3'd2,ON,ON,7'd0,12'h000,6'd0,6'd0,1'b1,1'b1,4'h0,6'd0},
    '{1,0,0,1,1,1,3'd6,ON,ON,7'd64,12'h000,6'd1,6'd1,1'b0,1'b1,4'h0,6'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic step, vf, vs, ms, rc, rtnz;
  logic [2:0] sel;
  logic [MAX_VL-1:0] sm, dm;
  logic [VL_W-1:0] vl;
  logic [11:0] rend;
  logic [IDX_W-1:0] src_o, dst_o, ret_o;
  logic end_o, valid_o;
  logic [3:0] cr_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vfs_step_ctrl #(.MAX_VL(MAX_VL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .vf_i(vf), .vs_i(vs), .ms_i(ms),
    .rc_i(rc), .rt_nz_i(rtnz), .sel_i(sel), .src_mask_i(sm), .dst_mask_i(dm),
    .vl_i(vl), .remap_end_i(rend), .src_step_o(src_o), .dst_step_o(dst_o),
    .end_o(end_o), .res_valid_o(valid_o), .cr_o(cr_o), .ret_o(ret_o)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    vf = v.vf; vs = v.vs; ms = v.ms; step = v.step; rc = v.rc; rtnz = v.rtnz;
    sel = v.sel; sm = v.sm; dm = v.dm; vl = v.vl; rend = v.rend;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    drive('0);
    repeat (3) @(negedge clk);
    // R1: values while held in reset
    chk("R1", "src", src_o, 0); chk("R1", "dst", dst_o, 0);
    chk("R1", "end", end_o, 0); chk("R1", "valid", valid_o, 0);
    chk("R1", "cr", cr_o, 0);   chk("R1", "ret", ret_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "src after release", src_o, 0);

    for (int k = 0; k < NV; k++) begin
      string rq;
      drive(TBL[k]);
      @(negedge clk);
      if (!TBL[k].step) rq = "R3";
      else if (!(TBL[k].vf && !TBL[k].vs && !TBL[k].ms)) rq = "R2";
      else rq = TBL[k].eend ? "R5" : "R4";
      chk(rq, "src", src_o, TBL[k].esrc);
      chk(rq, "dst", dst_o, TBL[k].edst);
      chk("R5", "end", end_o, TBL[k].eend);
      chk("R6", "valid", valid_o, TBL[k].evalid);
      chk((TBL[k].sel inside {[1:4]}) ? "R7" : "R8", "cr", cr_o, TBL[k].ecr);
      chk("R9", "ret", ret_o, TBL[k].eret);
    end

    // R6: pulse drops after idle cycle
    step = 1'b0;
    @(negedge clk);
    chk("R6", "valid drop", valid_o, 0);

    // R5: empty masks with full length end the vector
    vf = 1; vs = 0; ms = 0; step = 1; rc = 1; rtnz = 1; sel = 3'd7;
    sm = '0; dm = ON; vl = 7'd64; rend = 12'hFFF;
    @(negedge clk);
    chk("R5", "src empty", src_o, 0);
    chk("R5", "end empty", end_o, 1);
    chk("R8", "cr sel7", cr_o, 4'h8);
    chk("R9", "ret sel7", ret_o, 0);

    // R1: reset in mid-run clears nonzero state
    sm = ON; step = 1; sel = 3'd5;
    @(negedge clk);
    chk("R4", "src pre-reset", src_o, 1);
    step = 0;
    rst_n = 1'b0;
    #1;
    chk("R1", "src mid reset", src_o, 0);
    chk("R1", "ret mid reset", ret_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", valid_o, 0);

    finish_run();
  end
endmodule